// File: doc/BRIEF.md
# Serial Port with Run-Time Flow Control

This block is a full-duplex asynchronous serial port. One transmitter and one receiver sit behind a single control word. Bytes to send enter a transmit queue over a valid/ready stream. Received bytes leave a receive queue over a second valid/ready stream. Frames are one start bit, eight data bits sent least significant bit first, and one stop bit. Every bit lasts a fixed, parameterised number of clock cycles. The receiver oversamples the line by a parameterised factor and samples each bit at its centre.

The control word can switch either flow control on or off while traffic is running. With clear-to-send gating on, the transmitter starts a new character only while the active-low CTS input is low. With request-to-send gating on, the RTS output reflects the free space in the receive queue. When request-to-send gating is off, the four modem outputs simply follow their control bits, inverted. Clearing a direction's enable never cuts a character short: the character in flight completes first, and then that direction stops.

Top module: `uart_fc`

## Requirements
- R1: After reset the control word reads 0x0000_0300, meaning receive enable (bit 9) and transmit enable (bit 8) are 1 and all other bits are 0. After reset txd, rts_n, dtr_n, out1_n and out2_n are high, tx_ready is 1, rx_valid is 0 and rx_overrun is 0.
- R2: A write stores bits 15:8 of reg_wdata into the control word. reg_rdata returns them in the same bit positions, and bits 31:16 and 7:0 always read 0.
- R3: While bit 14 is 0, rts_n is the inverse of bit 11, dtr_n of bit 10, out1_n of bit 12 and out2_n of bit 13, from the cycle after the write.
- R4: Each character goes out on txd as a low start bit, then eight data bits least significant first, then a high stop bit, each CLKS_PER_BIT cycles long. The start bit begins the cycle after the byte leaves the transmit queue. txd is high when idle.
- R5: A well-formed frame on rxd is sampled at its bit centres and delivered on the rx stream, and bytes come out in arrival order.
- R6: While bit 15 is 1, a character starts only when the synchronised cts_n is low. Raising cts_n in the middle of a frame does not shorten that frame.
- R7: While bit 14 is 1, rts_n is low exactly when the receive queue holds fewer than FIFO_DEPTH-1 characters.
- R8: Clearing bit 8 during a frame lets that frame finish through its stop bit. After that no new character starts, and queued bytes stay in the queue until bit 8 is set again.
- R9: Clearing bit 9 during reception still stores the character being received. Frames that start later are ignored.
- R10: A character completed while the receive queue holds FIFO_DEPTH entries is dropped, and rx_overrun goes high and stays high.
- R11: The transmit queue accepts FIFO_DEPTH bytes, and tx_ready is low while it is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmit queue has room |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | rx_data is valid |
| rx_ready | input | 1 | Consumer takes rx_data |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| out1_n | output | 1 | General modem output 1, active low |
| out2_n | output | 1 | General modem output 2, active low |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
Some properties are checked on every cycle. A transmitted frame always opens with a low start bit and ends with a high stop bit, and once a frame starts it cannot be abandoned before its last bit. A disabled receiver stays idle, the overrun flag never falls, and the transmit queue count grows by exactly one on a lone push. Other behaviour needs the bench's scenarios. The exact txd waveform, the tx_ready level and the modem pin levels are compared each cycle against a behavioural model. The CTS gating decision taken at character boundaries, completion of a frame after an enable is cleared, the RTS threshold, and the dropping of an overflow byte all need their specific stimulus sequences to show.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
   // control word bit positions
   localparam int CTL_TXE   = 8;
   localparam int CTL_RXE   = 9;
   localparam int CTL_DTR   = 10;
   localparam int CTL_RTS   = 11;
   localparam int CTL_OUT1  = 12;
   localparam int CTL_OUT2  = 13;
   localparam int CTL_RTSFC = 14;
   localparam int CTL_CTSFC = 15;
   localparam logic [7:0] CTL_RESET = 8'h03; // bits 15:8
endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_fc_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) ff[0] <= 1'b1;
               else        ff[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) ff[i] <= 1'b1;
               else        ff[i] <= ff[i-1];
         end
      end
   endgenerate

   assign q = ff[STAGES-1];
endmodule

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("uart_fc_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk) if (do_push) mem[wp] <= wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   // R11: a lone accepted push raises the occupancy by exactly one
   p_count_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop) |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx #(
   parameter int CLKS_PER_BIT = 64,
   localparam int CYW = $clog2(CLKS_PER_BIT)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_ok,
   input  logic       avail,
   input  logic [7:0] data,
   output logic       pop,
   output logic       txd,
   output logic       busy
);
   logic [9:0]     sh;
   logic [3:0]     bitn;
   logic [CYW-1:0] cyc;

   assign pop = !busy && avail && go_ok;
   assign txd = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; sh <= '1; bitn <= '0; cyc <= '0;
      end else if (pop) begin
         busy <= 1'b1;
         sh   <= {1'b1, data, 1'b0};
         bitn <= '0;
         cyc  <= '0;
      end else if (busy) begin
         if (cyc == CYW'(CLKS_PER_BIT - 1)) begin
            cyc <= '0;
            sh  <= {1'b1, sh[9:1]};
            if (bitn == 4'd9) busy <= 1'b0;
            else              bitn <= bitn + 1'b1;
         end else begin
            cyc <= cyc + 1'b1;
         end
      end
   end

   // R4: every frame opens with a low start bit
   p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> txd == 1'b0);
   // R4: the tenth bit of a frame is a high stop bit
   p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bitn == 4'd9) |-> txd == 1'b1);
   // R8 / R6: a frame is never abandoned before its last bit
   p_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bitn != 4'd9) |=> busy);
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
   import uart_fc_pkg::*;
#(
   parameter int OVS = 16,
   localparam int OW = $clog2(OVS)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       rxd,
   output logic [7:0] dout,
   output logic       dstb
);
   rx_state_t     st;
   logic [OW-1:0] ocnt;
   logic [2:0]    bitn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RX_IDLE; ocnt <= '0; bitn <= '0; dout <= '0; dstb <= 1'b0;
      end else begin
         dstb <= 1'b0;
         case (st)
            RX_IDLE: begin
               ocnt <= '0;
               if (tick && en && !rxd) st <= RX_START;
            end
            RX_START: if (tick) begin
               if (ocnt == OW'(OVS/2 - 1)) begin
                  ocnt <= '0;
                  bitn <= '0;
                  st   <= rxd ? RX_IDLE : RX_DATA;
               end else ocnt <= ocnt + 1'b1;
            end
            RX_DATA: if (tick) begin
               if (ocnt == OW'(OVS - 1)) begin
                  ocnt <= '0;
                  dout <= {rxd, dout[7:1]};
                  if (bitn == 3'd7) st <= RX_STOP;
                  else              bitn <= bitn + 1'b1;
               end else ocnt <= ocnt + 1'b1;
            end
            default: if (tick) begin
               if (ocnt == OW'(OVS - 1)) begin
                  st   <= RX_IDLE;
                  dstb <= rxd;
               end else ocnt <= ocnt + 1'b1;
            end
         endcase
      end
   end

   // R9: a disabled receiver never leaves idle
   p_en_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_IDLE && !en) |=> st == RX_IDLE);
   // R5: one strobe per character
   p_one_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dstb |=> !dstb);
endmodule

// File: rtl/uart_fc.sv
module uart_fc
   import uart_fc_pkg::*;
#(
   parameter int CLKS_PER_BIT = 64,
   parameter int OVS          = 16,
   parameter int FIFO_DEPTH   = 16,
   parameter int SYNC_STAGES  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic [7:0]  tx_data,
   input  logic        tx_valid,
   output logic        tx_ready,
   output logic [7:0]  rx_data,
   output logic        rx_valid,
   input  logic        rx_ready,
   output logic        txd,
   input  logic        rxd,
   input  logic        cts_n,
   output logic        rts_n,
   output logic        dtr_n,
   output logic        out1_n,
   output logic        out2_n,
   output logic        rx_overrun
);
   localparam int TICK_DIV = CLKS_PER_BIT / OVS;
   localparam int TW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam int CW       = $clog2(FIFO_DEPTH + 1);

   generate
      if ((CLKS_PER_BIT % OVS) != 0 || TICK_DIV < 1) begin : g_bad_div
         $error("uart_fc: CLKS_PER_BIT must be a nonzero multiple of OVS");
      end
      if (OVS < 4) begin : g_bad_ovs
         $error("uart_fc: OVS must be at least 4");
      end
   endgenerate

   logic [15:8] ctl;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      ctl <= CTL_RESET;
      else if (reg_wr) ctl <= reg_wdata[15:8];
   assign reg_rdata = {16'h0, ctl, 8'h0};

   logic cts_s, rxd_s;
   uart_fc_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (.clk, .rst_n, .d(cts_n), .q(cts_s));
   uart_fc_sync #(.STAGES(SYNC_STAGES)) u_rxd_sync (.clk, .rst_n, .d(rxd),   .q(rxd_s));

   // oversampling tick
   logic          tick;
   logic [TW-1:0] tcnt;
   assign tick = (tcnt == TW'(TICK_DIV - 1));
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    tcnt <= '0;
      else if (tick) tcnt <= '0;
      else           tcnt <= tcnt + 1'b1;

   // transmit path
   logic [7:0]    txq_data;
   logic          txq_full, txq_empty, txq_pop, tx_busy, tx_go;
   logic [CW-1:0] txq_cnt;
   assign tx_ready = !txq_full;
   assign tx_go    = ctl[CTL_TXE] && (!ctl[CTL_CTSFC] || !cts_s);

   uart_fc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk, .rst_n, .push(tx_valid), .wdata(tx_data), .pop(txq_pop),
      .rdata(txq_data), .full(txq_full), .empty(txq_empty), .count(txq_cnt));

   uart_fc_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
      .clk, .rst_n, .go_ok(tx_go), .avail(!txq_empty), .data(txq_data),
      .pop(txq_pop), .txd, .busy(tx_busy));

   // receive path
   logic [7:0]    rx_byte;
   logic          rx_stb, rxq_full, rxq_empty;
   logic [CW-1:0] rxq_cnt;
   assign rx_valid = !rxq_empty;

   uart_fc_rx #(.OVS(OVS)) u_rx (
      .clk, .rst_n, .tick, .en(ctl[CTL_RXE]), .rxd(rxd_s),
      .dout(rx_byte), .dstb(rx_stb));

   uart_fc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk, .rst_n, .push(rx_stb), .wdata(rx_byte), .pop(rx_ready),
      .rdata(rx_data), .full(rxq_full), .empty(rxq_empty), .count(rxq_cnt));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                   rx_overrun <= 1'b0;
      else if (rx_stb && rxq_full)  rx_overrun <= 1'b1;

   // modem outputs
   assign rts_n  = ctl[CTL_RTSFC] ? (rxq_cnt >= CW'(FIFO_DEPTH - 1)) : !ctl[CTL_RTS];
   assign dtr_n  = !ctl[CTL_DTR];
   assign out1_n = !ctl[CTL_OUT1];
   assign out2_n = !ctl[CTL_OUT2];

   // R10: the overrun flag never clears
   p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |=> rx_overrun);
   // R7: an asserted RTS leaves room for the one character that may follow
   p_rts_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[CTL_RTSFC] && !rts_n) |=> rxq_cnt <= CW'(FIFO_DEPTH - 1));
endmodule

// File: tb/uart_fc_bench.sv
module uart_fc_bench;
   localparam int CPB   = 64;
   localparam int DEPTH = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0] tx_data = '0;
   logic tx_valid = 1'b0, tx_ready;
   logic [7:0] rx_data;
   logic rx_valid, rx_ready = 1'b1;
   logic txd, rxd = 1'b1, cts_n = 1'b0;
   logic rts_n, dtr_n, out1_n, out2_n, rx_overrun;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   uart_fc #(.CLKS_PER_BIT(CPB), .OVS(16), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) u_uart_fc (
      .clk, .rst_n, .reg_wr, .reg_wdata, .reg_rdata, .tx_data, .tx_valid, .tx_ready,
      .rx_data, .rx_valid, .rx_ready, .txd, .rxd, .cts_n, .rts_n, .dtr_n,
      .out1_n, .out2_n, .rx_overrun);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic [7:0] m_ctl;
   bit m_c1, m_c2;
   byte unsigned m_q[$];
   byte unsigned rx_got[$];
   bit m_busy;
   int m_pos, m_cyc;
   logic [9:0] m_frame;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = 8'h03; m_c1 = 1; m_c2 = 1; m_q.delete(); m_busy = 0; m_pos = 0; m_cyc = 0;
      end else begin
         bit ready_now;
         ready_now = (m_q.size() < DEPTH);
         if (rx_valid && rx_ready) rx_got.push_back(rx_data);
         if (!m_busy) begin
            if (m_q.size() > 0 && m_ctl[0] && (!m_ctl[7] || !m_c2)) begin
               m_busy = 1; m_frame = {1'b1, m_q.pop_front(), 1'b0}; m_pos = 0; m_cyc = 0;
            end
         end else if (m_cyc == CPB - 1) begin
            m_cyc = 0;
            if (m_pos == 9) m_busy = 0; else m_pos++;
         end else m_cyc++;
         if (tx_valid && ready_now) m_q.push_back(tx_data);
         m_c2 = m_c1; m_c1 = cts_n;
         if (reg_wr) m_ctl = reg_wdata[15:8];
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) if (rst_n && !done) begin
      chk(txd === (m_busy ? m_frame[m_pos] : 1'b1), "R4 txd", txd, m_busy ? m_frame[m_pos] : 1);
      chk(tx_ready === (m_q.size() < DEPTH), "R11 tx_ready", tx_ready, m_q.size() < DEPTH);
      chk(reg_rdata === {16'h0, m_ctl, 8'h0}, "R2 readback", reg_rdata, {16'h0, m_ctl, 8'h0});
      chk(dtr_n === !m_ctl[2] && out1_n === !m_ctl[4] && out2_n === !m_ctl[5],
          "R3 modem pins", {dtr_n, out1_n, out2_n}, {!m_ctl[2], !m_ctl[4], !m_ctl[5]});
      if (!m_ctl[6]) chk(rts_n === !m_ctl[3], "R3 rts_n", rts_n, !m_ctl[3]);
   end

   task automatic wr(input logic [31:0] v);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic push(input byte unsigned b);
      @(negedge clk); tx_valid = 1'b1; tx_data = b;
      while (!tx_ready) @(negedge clk);
      @(negedge clk); tx_valid = 1'b0;
   endtask

   task automatic wait_tx_idle();
      do @(negedge clk); while (m_busy || m_q.size() > 0);
   endtask

   task automatic send(input byte unsigned b);
      logic [9:0] f;
      f = {1'b1, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         rxd = f[i];
         repeat (CPB) @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(reg_rdata == 32'h0000_0300, "R1 ctl", reg_rdata, 32'h300);
      chk({txd, rts_n, dtr_n, out1_n, out2_n} == 5'b11111, "R1 pins",
          {txd, rts_n, dtr_n, out1_n, out2_n}, 5'b11111);
      chk(tx_ready && !rx_valid && !rx_overrun, "R1 streams",
          {tx_ready, rx_valid, rx_overrun}, 3'b100);

      // R2 register width
      wr(32'hFFFF_FFFF);
      chk(reg_rdata == 32'h0000_FF00, "R2 mask", reg_rdata, 32'hFF00);
      // R3 manual modem outputs
      wr(32'h0000_3C00);
      chk({rts_n, dtr_n, out1_n, out2_n} == 4'b0000, "R3 all low",
          {rts_n, dtr_n, out1_n, out2_n}, 0);
      wr(32'h0000_2400);
      chk({rts_n, dtr_n, out1_n, out2_n} == 4'b1010, "R3 mixed",
          {rts_n, dtr_n, out1_n, out2_n}, 4'b1010);
      wr(32'h0000_0300);

      // R4 framing, several byte patterns
      push(8'hA5); push(8'h3C); push(8'h01);
      wait_tx_idle();
      chk(txd == 1'b1, "R4 idle high", txd, 1);

      // R11 queue depth
      wr(32'h0000_0200);
      for (int i = 0; i < DEPTH; i++) push(byte'(i * 17 + 3));
      @(negedge clk);
      chk(tx_ready == 1'b0, "R11 full", tx_ready, 0);
      wr(32'h0000_0300);
      wait_tx_idle();

      // R6 CTS gating
      cts_n = 1'b1;
      wr(32'h0000_8300);
      push(8'h5A);
      repeat (300) @(negedge clk);
      chk(txd == 1'b1 && !m_busy, "R6 held off", txd, 1);
      cts_n = 1'b0;
      repeat (3 * CPB) @(negedge clk);
      cts_n = 1'b1;
      wait_tx_idle();
      chk(txd == 1'b1, "R6 frame completed", txd, 1);
      cts_n = 1'b0;
      wr(32'h0000_0300);

      // R8 transmit disable mid-frame
      push(8'h81); push(8'h7E);
      repeat (300) @(negedge clk);
      wr(32'h0000_0200);
      while (m_busy) @(negedge clk);
      begin
         int lows = 0;
         for (int i = 0; i < 12 * CPB; i++) begin
            @(negedge clk);
            if (!txd) lows++;
         end
         chk(lows == 0, "R8 no new frame", lows, 0);
      end
      wr(32'h0000_0300);
      wait_tx_idle();
      chk(txd == 1'b1, "R8 resumed", txd, 1);

      // R5 reception
      send(8'h55); send(8'hC3);
      repeat (50) @(negedge clk);
      chk(rx_got.size() == 2, "R5 count", rx_got.size(), 2);
      if (rx_got.size() >= 2) begin
         chk(rx_got[0] == 8'h55, "R5 byte0", rx_got[0], 8'h55);
         chk(rx_got[1] == 8'hC3, "R5 byte1", rx_got[1], 8'hC3);
      end

      // R9 receive disable mid-frame
      fork
         send(8'h96);
         begin repeat (3 * CPB) @(negedge clk); wr(32'h0000_0100); end
      join
      repeat (50) @(negedge clk);
      chk(rx_got.size() == 3, "R9 finished char", rx_got.size(), 3);
      if (rx_got.size() >= 3) chk(rx_got[2] == 8'h96, "R9 value", rx_got[2], 8'h96);
      send(8'h11);
      repeat (50) @(negedge clk);
      chk(rx_got.size() == 3 && !rx_valid, "R9 ignored", rx_got.size(), 3);

      // R7 RTS threshold and R10 overrun
      rx_ready = 1'b0;
      wr(32'h0000_4300);
      @(negedge clk);
      chk(rts_n == 1'b0, "R7 empty", rts_n, 0);
      for (int i = 0; i < DEPTH - 2; i++) send(byte'(8'h20 + i));
      repeat (20) @(negedge clk);
      chk(rts_n == 1'b0, "R7 at depth-2", rts_n, 0);
      send(byte'(8'h20 + DEPTH - 2));
      repeat (20) @(negedge clk);
      chk(rts_n == 1'b1, "R7 at depth-1", rts_n, 1);
      chk(rx_overrun == 1'b0, "R10 not yet", rx_overrun, 0);
      send(byte'(8'h20 + DEPTH - 1));
      send(8'hEE);
      repeat (20) @(negedge clk);
      chk(rx_overrun == 1'b1, "R10 set", rx_overrun, 1);
      rx_ready = 1'b1;
      repeat (50) @(negedge clk);
      chk(rx_got.size() == 3 + DEPTH, "R10 dropped", rx_got.size(), 3 + DEPTH);
      for (int i = 0; i < DEPTH; i++)
         if (rx_got.size() > 3 + i)
            chk(rx_got[3 + i] == byte'(8'h20 + i), "R5 order", rx_got[3 + i], 8'h20 + i);
      chk(rx_overrun == 1'b1, "R10 sticky", rx_overrun, 1);
      chk(rts_n == 1'b0, "R7 drained", rts_n, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule